// File: doc/BRIEF.md
# Unary Shift and Complement Unit

This block is the single-operand slice of the arithmetic unit of an 8-bit accumulator machine. It is purely combinational. It takes a 4-bit operation code, a 16-bit operand (the high byte and the low byte of a paired accumulator) and the incoming carry. It returns the result and four condition flags: negative, zero, overflow and carry.

The operations are two's complement negate, bitwise invert, clear, increment, decrement, rotate through carry in both directions, the left shift, arithmetic and logical right shifts, and 16-bit logical left and right shifts across the whole operand. Every operation has its own rule for the flags. Next to each flag value the unit drives an update enable. Flags that an operation does not touch come out with the enable low, and the surrounding condition register keeps its old bit.

Inside, a control module turns the operation code into a packed bundle of strobes: the result source, the operand width, the shift fill bit, the overflow rule, the carry rule and the flag enables. A datapath module computes the result and the flags from that bundle.

Top module: `ushift_unit`

## Requirements
- R1: Op code 0 (negate) returns (0 - low byte) mod 256 in the low byte and enables all four flags. N is result bit 7, Z is set when the result is zero, V is set only when the result is 0x80 (operand 0x80 comes back unchanged), and C is set when the result is non-zero.
- R2: Op code 1 (invert) returns the bitwise inverse of the low byte, sets N and Z from the result, clears V, sets C, and enables all four flags.
- R3: Op code 2 (clear) returns a zero low byte with flags N=0, Z=1, V=0, C=0 and all four enables high.
- R4: Op code 3 (increment) and op code 4 (decrement) return the low byte plus or minus one, modulo 256. N, Z and V are enabled and the carry enable is low. V is set when incrementing 0x7F or when decrementing 0x80.
- R5: Op code 5 (rotate left) shifts the low byte left, with the incoming carry entering bit 0 and bit 7 leaving as C. Op code 6 (rotate right) shifts it right, with the incoming carry entering bit 7 and bit 0 leaving as C.
- R6: Op code 7 (left shift) sends bit 7 to C and a zero into bit 0. Op code 8 (arithmetic right shift) sends bit 0 to C and keeps bit 7. Op code 9 (logical right shift) sends bit 0 to C and a zero into bit 7. None of the three depends on the incoming carry.
- R7: Op code 10 shifts the whole 16-bit operand left, with bit 15 going to C and a zero into bit 0. Op code 11 shifts it right, with bit 0 going to C and a zero into bit 15. For both, N is result bit 15 and Z covers all 16 bits.
- R8: Every shift and rotate (op codes 5 to 11) enables all four flags, and V equals N XOR C.
- R9: For op codes 0 to 9 the high byte of the result equals the high byte of the operand.
- R10: Op codes 12 to 15 return the operand unchanged with all flag enables low.
- R11: The flag output and the enable output both order their bits as N=bit 3, Z=bit 2, V=bit 1, C=bit 0, and a flag whose enable is low is driven as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 4 | Operation code (0 to 11 defined, 12 to 15 pass the operand through) |
| operandIn | input | 16 | High byte in bits 15:8, low byte in bits 7:0 |
| carryIn | input | 1 | Current carry flag, used by the rotates |
| resultOut | output | 16 | Result |
| flagOut | output | 4 | New flag values {N,Z,V,C}, zero where not enabled |
| flagEn | output | 4 | Per-flag update enables {N,Z,V,C} |

## Verification
Each operation is driven with the operand values that separate its flag rules.

- **Negate** gets 0x00, 0x01, 0x80 and 0xFF. These tell the zero, non-zero and self-negating cases apart for C and V.
- **Increment and decrement** get 0x7F, 0x80, 0xFF and 0x00. These hit the signed overflow points and the wrap points, and the bench confirms the carry enable stays low at each of them.
- **Rotates and shifts** get operands with distinct end bits, each with the incoming carry at both 0 and 1. This separates rotating through carry from zero fill and sign fill, and it makes V = N XOR C take both values.
- **16-bit shifts** get patterns whose carry crosses the byte boundary, and a single set bit whose shift leaves a zero result.
- **The remaining cases** check that narrow operations carry the high byte through unchanged, and that the undefined op codes leave everything untouched.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

  typedef enum logic [3:0] {
    OP_NEG  = 4'd0,
    OP_COM  = 4'd1,
    OP_CLR  = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_ROL  = 4'd5,
    OP_ROR  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SAR  = 4'd8,
    OP_SHR  = 4'd9,
    OP_SHLW = 4'd10,
    OP_SHRW = 4'd11
  } unaryOpE;

  typedef enum logic [2:0] {
    SRC_PASS,
    SRC_NEG,
    SRC_COM,
    SRC_CLR,
    SRC_INC,
    SRC_DEC,
    SRC_SHL,
    SRC_SHR
  } srcSelE;

  typedef enum logic [1:0] {
    FILL_ZERO,
    FILL_CARRY,
    FILL_SIGN
  } fillSelE;

  typedef enum logic [2:0] {
    V_CLEAR,
    V_NXORC,
    V_NEGOVF,
    V_INCOVF,
    V_DECOVF
  } vRuleE;

  typedef enum logic [1:0] {
    C_CLEAR,
    C_SET,
    C_SHIFTOUT,
    C_NONZERO
  } cRuleE;

  localparam int FlagN = 3;
  localparam int FlagZ = 2;
  localparam int FlagV = 1;
  localparam int FlagC = 0;
  localparam int FlagCount = 4;

  typedef struct packed {
    srcSelE               src;
    logic                 wide;
    fillSelE              fill;
    vRuleE                vRule;
    cRuleE                cRule;
    logic [FlagCount-1:0] flagEn;
  } strobeT;

endpackage

// File: rtl/ushift_ctrl.sv
module ushift_ctrl
  import ushift_pkg::*;
(
  input  logic [3:0] opSel,
  output strobeT     strobe
);

  localparam logic [FlagCount-1:0] AllFlags = '1;
  localparam logic [FlagCount-1:0] NoCarry  = 4'b1110;

  always_comb begin
    strobe.src    = SRC_PASS;
    strobe.wide   = 1'b0;
    strobe.fill   = FILL_ZERO;
    strobe.vRule  = V_CLEAR;
    strobe.cRule  = C_CLEAR;
    strobe.flagEn = '0;
    case (opSel)
      OP_NEG: begin
        strobe.src    = SRC_NEG;
        strobe.vRule  = V_NEGOVF;
        strobe.cRule  = C_NONZERO;
        strobe.flagEn = AllFlags;
      end
      OP_COM: begin
        strobe.src    = SRC_COM;
        strobe.cRule  = C_SET;
        strobe.flagEn = AllFlags;
      end
      OP_CLR: begin
        strobe.src    = SRC_CLR;
        strobe.flagEn = AllFlags;
      end
      OP_INC: begin
        strobe.src    = SRC_INC;
        strobe.vRule  = V_INCOVF;
        strobe.flagEn = NoCarry;
      end
      OP_DEC: begin
        strobe.src    = SRC_DEC;
        strobe.vRule  = V_DECOVF;
        strobe.flagEn = NoCarry;
      end
      OP_ROL: begin
        strobe.src    = SRC_SHL;
        strobe.fill   = FILL_CARRY;
        strobe.vRule  = V_NXORC;
        strobe.cRule  = C_SHIFTOUT;
        strobe.flagEn = AllFlags;
      end
      OP_ROR: begin
        strobe.src    = SRC_SHR;
        strobe.fill   = FILL_CARRY;
        strobe.vRule  = V_NXORC;
        strobe.cRule  = C_SHIFTOUT;
        strobe.flagEn = AllFlags;
      end
      OP_SHL: begin
        strobe.src    = SRC_SHL;
        strobe.vRule  = V_NXORC;
        strobe.cRule  = C_SHIFTOUT;
        strobe.flagEn = AllFlags;
      end
      OP_SAR: begin
        strobe.src    = SRC_SHR;
        strobe.fill   = FILL_SIGN;
        strobe.vRule  = V_NXORC;
        strobe.cRule  = C_SHIFTOUT;
        strobe.flagEn = AllFlags;
      end
      OP_SHR: begin
        strobe.src    = SRC_SHR;
        strobe.vRule  = V_NXORC;
        strobe.cRule  = C_SHIFTOUT;
        strobe.flagEn = AllFlags;
      end
      OP_SHLW: begin
        strobe.src    = SRC_SHL;
        strobe.wide   = 1'b1;
        strobe.vRule  = V_NXORC;
        strobe.cRule  = C_SHIFTOUT;
        strobe.flagEn = AllFlags;
      end
      OP_SHRW: begin
        strobe.src    = SRC_SHR;
        strobe.wide   = 1'b1;
        strobe.vRule  = V_NXORC;
        strobe.cRule  = C_SHIFTOUT;
        strobe.flagEn = AllFlags;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ushift_datapath.sv
module ushift_datapath
  import ushift_pkg::*;
#(
  parameter int ByteW = 8
) (
  input  strobeT                  strobe,
  input  logic [2*ByteW-1:0]      operandIn,
  input  logic                    carryIn,
  output logic [2*ByteW-1:0]      resultOut,
  output logic [FlagCount-1:0]    flagOut
);

  localparam int WordW = 2 * ByteW;
  localparam logic [ByteW-1:0] One    = ByteW'(1);
  localparam logic [ByteW-1:0] MinNeg = {1'b1, {(ByteW-1){1'b0}}};
  localparam logic [ByteW-1:0] MaxPos = ~MinNeg;

  logic [ByteW-1:0] loByte;
  logic [ByteW-1:0] hiByte;
  logic             fillBit;
  logic [ByteW-1:0] narrowRes;
  logic             narrowOut;
  logic [WordW-1:0] wideRes;
  logic             wideOut;
  logic             shiftOut;
  logic             nBit;
  logic             zBit;
  logic             vBit;
  logic             cBit;

  assign loByte = operandIn[ByteW-1:0];
  assign hiByte = operandIn[WordW-1:ByteW];

  always_comb begin
    case (strobe.fill)
      FILL_CARRY: fillBit = carryIn;
      FILL_SIGN:  fillBit = strobe.wide ? operandIn[WordW-1] : loByte[ByteW-1];
      default:    fillBit = 1'b0;
    endcase
  end

  always_comb begin
    narrowOut = 1'b0;
    case (strobe.src)
      SRC_NEG:  narrowRes = ~loByte + One;
      SRC_COM:  narrowRes = ~loByte;
      SRC_CLR:  narrowRes = '0;
      SRC_INC:  narrowRes = loByte + One;
      SRC_DEC:  narrowRes = loByte - One;
      SRC_SHL: begin
        narrowRes = {loByte[ByteW-2:0], fillBit};
        narrowOut = loByte[ByteW-1];
      end
      SRC_SHR: begin
        narrowRes = {fillBit, loByte[ByteW-1:1]};
        narrowOut = loByte[0];
      end
      default:  narrowRes = loByte;
    endcase
  end

  always_comb begin
    if (strobe.src == SRC_SHL) begin
      wideRes = {operandIn[WordW-2:0], fillBit};
      wideOut = operandIn[WordW-1];
    end else begin
      wideRes = {fillBit, operandIn[WordW-1:1]};
      wideOut = operandIn[0];
    end
  end

  assign resultOut = strobe.wide ? wideRes : {hiByte, narrowRes};
  assign shiftOut  = strobe.wide ? wideOut : narrowOut;
  assign nBit      = strobe.wide ? wideRes[WordW-1] : narrowRes[ByteW-1];
  assign zBit      = strobe.wide ? (wideRes == '0) : (narrowRes == '0);

  always_comb begin
    case (strobe.cRule)
      C_SET:      cBit = 1'b1;
      C_SHIFTOUT: cBit = shiftOut;
      C_NONZERO:  cBit = (narrowRes != '0);
      default:    cBit = 1'b0;
    endcase
  end

  always_comb begin
    case (strobe.vRule)
      V_NXORC:  vBit = nBit ^ cBit;
      V_NEGOVF: vBit = (narrowRes == MinNeg);
      V_INCOVF: vBit = (loByte == MaxPos);
      V_DECOVF: vBit = (loByte == MinNeg);
      default:  vBit = 1'b0;
    endcase
  end

  always_comb begin
    flagOut        = '0;
    flagOut[FlagN] = nBit;
    flagOut[FlagZ] = zBit;
    flagOut[FlagV] = vBit;
    flagOut[FlagC] = cBit;
    flagOut        = flagOut & strobe.flagEn;
  end

endmodule

// File: rtl/ushift_unit.sv
module ushift_unit
  import ushift_pkg::*;
#(
  parameter int ByteW = 8
) (
  input  logic [3:0]         opSel,
  input  logic [2*ByteW-1:0] operandIn,
  input  logic               carryIn,
  output logic [2*ByteW-1:0] resultOut,
  output logic [3:0]         flagOut,
  output logic [3:0]         flagEn
);

  strobeT strobe;

  ushift_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  ushift_datapath #(.ByteW(ByteW)) u_dp (
    .strobe    (strobe),
    .operandIn (operandIn),
    .carryIn   (carryIn),
    .resultOut (resultOut),
    .flagOut   (flagOut)
  );

  assign flagEn = strobe.flagEn;

endmodule

// File: rtl/ushift_checker.sv
module ushift_checker #(
  parameter int ByteW = 8
) (
  input logic [3:0]         opSel,
  input logic [2*ByteW-1:0] operandIn,
  input logic               carryIn,
  input logic [2*ByteW-1:0] resultOut,
  input logic [3:0]         flagOut,
  input logic [3:0]         flagEn
);

  localparam int WordW = 2 * ByteW;

  logic unusedCarry;
  assign unusedCarry = carryIn;

  always_comb begin
    if (opSel == 4'd0)
      AST_NEG_ZERO_FLAG: assert (flagOut[2] == (resultOut[ByteW-1:0] == '0)); // R1
    if (opSel == 4'd1)
      AST_COM_VC: assert (flagOut[1:0] == 2'b01 && resultOut[ByteW-1:0] == ~operandIn[ByteW-1:0]); // R2
    if (opSel == 4'd2)
      AST_CLR_FLAGS: assert (resultOut[ByteW-1:0] == '0 && flagOut == 4'b0100 && flagEn == 4'hF); // R3
    if (opSel == 4'd3 || opSel == 4'd4)
      AST_KEEP_CARRY: assert (flagEn == 4'b1110 && !flagOut[0]); // R4
    if (opSel >= 4'd5 && opSel <= 4'd11)
      AST_SHIFT_V: assert (flagEn == 4'hF && flagOut[1] == (flagOut[3] ^ flagOut[0])); // R8
    if (opSel <= 4'd9)
      AST_HIGH_PASS: assert (resultOut[WordW-1:ByteW] == operandIn[WordW-1:ByteW]); // R9
    if (opSel >= 4'd12)
      AST_IDLE_PASS: assert (flagEn == 4'h0 && flagOut == 4'h0 && resultOut == operandIn); // R10
    AST_DISABLED_ZERO: assert ((flagOut & ~flagEn) == 4'h0); // R11
  end

endmodule

bind ushift_unit ushift_checker #(.ByteW(ByteW)) u_chk (
  .opSel     (opSel),
  .operandIn (operandIn),
  .carryIn   (carryIn),
  .resultOut (resultOut),
  .flagOut   (flagOut),
  .flagEn    (flagEn)
);

// File: tb/sim_ushift_unit.sv
module sim_ushift_unit;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opSel = 4'd15;
  logic [15:0] operandIn = 16'h0000;
  logic        carryIn = 1'b0;
  logic [15:0] resultOut;
  logic [3:0]  flagOut;
  logic [3:0]  flagEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  ushift_unit u0 (
    .opSel     (opSel),
    .operandIn (operandIn),
    .carryIn   (carryIn),
    .resultOut (resultOut),
    .flagOut   (flagOut),
    .flagEn    (flagEn)
  );

  // Expected {result, flags, enables}, flags and enables ordered {N,Z,V,C}
  function automatic logic [23:0] model(input logic [3:0] op, input logic [15:0] x, input logic cin);
    logic [7:0] lo, r;
    logic [15:0] w;
    logic n, z, v, c;
    logic [3:0] en;
    lo = x[7:0]; r = lo; w = x;
    n = 1'b0; z = 1'b0; v = 1'b0; c = 1'b0; en = 4'h0;
    case (op)
      4'd0: begin r = 8'h00 - lo; n = r[7]; z = (r == 8'h00); v = (r == 8'h80); c = (r != 8'h00); en = 4'hF; end
      4'd1: begin r = ~lo; n = r[7]; z = (r == 8'h00); c = 1'b1; en = 4'hF; end
      4'd2: begin r = 8'h00; z = 1'b1; en = 4'hF; end
      4'd3: begin r = lo + 8'h01; n = r[7]; z = (r == 8'h00); v = (lo == 8'h7F); en = 4'hE; end
      4'd4: begin r = lo - 8'h01; n = r[7]; z = (r == 8'h00); v = (lo == 8'h80); en = 4'hE; end
      4'd5: begin r = {lo[6:0], cin}; c = lo[7]; end
      4'd6: begin r = {cin, lo[7:1]}; c = lo[0]; end
      4'd7: begin r = {lo[6:0], 1'b0}; c = lo[7]; end
      4'd8: begin r = {lo[7], lo[7:1]}; c = lo[0]; end
      4'd9: begin r = {1'b0, lo[7:1]}; c = lo[0]; end
      4'd10: begin w = {x[14:0], 1'b0}; c = x[15]; end
      4'd11: begin w = {1'b0, x[15:1]}; c = x[0]; end
      default: ;
    endcase
    if (op >= 4'd5 && op <= 4'd9) begin
      n = r[7]; z = (r == 8'h00); v = n ^ c; en = 4'hF;
    end
    if (op == 4'd10 || op == 4'd11) begin
      n = w[15]; z = (w == 16'h0000); v = n ^ c; en = 4'hF;
    end
    if (op <= 4'd9) w = {x[15:8], r};
    return {w, {n, z, v, c} & en, en};
  endfunction

  task automatic checkOp(input logic [3:0] op, input logic [15:0] x, input logic cin, input string tag);
    logic [23:0] exp;
    exp = model(op, x, cin);
    @(negedge clk);
    opSel = op; operandIn = x; carryIn = cin;
    #1;
    checks++;
    if ({resultOut, flagOut, flagEn} !== exp) begin
      fails++;
      $display("FAIL %s op=%0d x=%h cin=%b: got res=%h flags=%b en=%b, expected res=%h flags=%b en=%b",
               tag, op, x, cin, resultOut, flagOut, flagEn, exp[23:8], exp[7:4], exp[3:0]);
    end
  endtask

  task automatic testIdleStart();
    @(negedge clk);
    #1;
    checks++;
    if (resultOut !== 16'h0000 || flagEn !== 4'h0 || flagOut !== 4'h0) begin
      fails++;
      $display("FAIL R10 start: got res=%h flags=%b en=%b, expected res=0000 flags=0000 en=0000",
               resultOut, flagOut, flagEn);
    end
  endtask

  task automatic testNegate();
    checkOp(4'd0, 16'h0000, 1'b0, "R1");
    checkOp(4'd0, 16'h0001, 1'b0, "R1");
    checkOp(4'd0, 16'h0080, 1'b1, "R1");
    checkOp(4'd0, 16'h00FF, 1'b0, "R1");
  endtask

  task automatic testInvertClear();
    checkOp(4'd1, 16'h00FF, 1'b0, "R2");
    checkOp(4'd1, 16'h0055, 1'b0, "R2");
    checkOp(4'd2, 16'h00A7, 1'b1, "R3");
    checkOp(4'd2, 16'h0000, 1'b0, "R3");
  endtask

  task automatic testIncDec();
    checkOp(4'd3, 16'h007F, 1'b1, "R4");
    checkOp(4'd3, 16'h00FF, 1'b1, "R4");
    checkOp(4'd3, 16'h0010, 1'b0, "R4");
    checkOp(4'd4, 16'h0080, 1'b1, "R4");
    checkOp(4'd4, 16'h0000, 1'b0, "R4");
    checkOp(4'd4, 16'h0001, 1'b0, "R4");
  endtask

  task automatic testRotates();
    for (int k = 0; k < 2; k++) begin
      checkOp(4'd5, 16'h0081, logic'(k), "R5");
      checkOp(4'd5, 16'h0040, logic'(k), "R8");
      checkOp(4'd6, 16'h0081, logic'(k), "R5");
      checkOp(4'd6, 16'h0002, logic'(k), "R8");
    end
  endtask

  task automatic testShifts();
    for (int k = 0; k < 2; k++) begin
      checkOp(4'd7, 16'h00C1, logic'(k), "R6");
      checkOp(4'd7, 16'h0080, logic'(k), "R8");
      checkOp(4'd8, 16'h0081, logic'(k), "R6");
      checkOp(4'd8, 16'h0042, logic'(k), "R6");
      checkOp(4'd9, 16'h0081, logic'(k), "R6");
      checkOp(4'd9, 16'h0001, logic'(k), "R8");
    end
  endtask

  task automatic testWide();
    checkOp(4'd10, 16'h4080, 1'b1, "R7");
    checkOp(4'd10, 16'h8000, 1'b0, "R7");
    checkOp(4'd10, 16'hC001, 1'b0, "R7");
    checkOp(4'd11, 16'h0101, 1'b1, "R7");
    checkOp(4'd11, 16'h0001, 1'b0, "R7");
    checkOp(4'd11, 16'h8000, 1'b1, "R7");
  endtask

  task automatic testHighByte();
    for (int op = 0; op < 10; op++)
      checkOp(op[3:0], 16'hA55A, 1'b1, "R9");
  endtask

  task automatic testIdleOps();
    for (int op = 12; op < 16; op++)
      checkOp(op[3:0], 16'h9C3E, 1'b1, "R10");
    checkOp(4'd15, 16'hFFFF, 1'b0, "R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testIdleStart();
    testNegate();
    testInvertClear();
    testIncDec();
    testRotates();
    testShifts();
    testWide();
    testHighByte();
    testIdleOps();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule